// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block sits between a raw link-status indication and the logic that acts on link state. A link-up report is passed on only after the raw indication has stayed high, with no gap, for a stability period. The period is selected by a 3-bit code. Loss of link is passed on at once, so the qualified output falls on the clock after the raw signal drops.

Time is counted in microseconds. A prescaler divides the free-running clock, whose frequency in MHz is a parameter, into one tick per microsecond. A saturating counter accumulates those ticks while the raw link is high. The selection code is captured only while the raw link is low. A code change therefore applies from the next qualification attempt and never to an attempt already under way.

Top module: `link_stability_qualifier`

## Requirements
- R1: The selection code maps to a stability period as follows: 0 gives none, 1 gives 500 us, 2 gives 1000 us, 3 gives 64000 us, 4 gives 256000 us, 5 gives 512000 us, 6 gives 1000000 us and 7 gives 2000000 us.
- R2: With a non-zero period of N microseconds and CLK_MHZ clocks per microsecond, call the first rising edge that samples `link_raw` high edge 0. `link_up` rises at edge N*CLK_MHZ, provided `link_raw` is sampled high on every edge up to and including that one. It is low before that edge.
- R3: With code 0 selected, `link_up` rises on edge 0, the first edge that samples `link_raw` high.
- R4: On any edge that samples `link_raw` low, `link_up` is cleared.
- R5: If `link_raw` is sampled low at any edge during the stability window, the elapsed time is discarded. The window then starts again from zero at the next edge that samples `link_raw` high.
- R6: The selection code is captured only on edges that sample `link_raw` low. A code change made while `link_raw` is high affects neither the running window nor a link that is already up.
- R7: After reset `link_up` is low. Until the first edge that samples `link_raw` low, the selection is code 2 (1000 us).
- R8: `link_up` never rises on an edge that samples `link_raw` low. It stays low for as long as `link_raw` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_raw | input | 1 | Unfiltered link status, synchronous to clk |
| period_sel | input | 3 | Stability period selection code |
| link_up | output | 1 | Qualified link status |

## Verification
The assertions assume that `link_raw` and `period_sel` are already synchronous to `clk`. They also assume that CLK_MHZ matches the real clock, because every window check counts edges rather than time. The bench changes both inputs only on falling clock edges. It sets a new code only while the link is low and then leaves at least one rising edge before raising the link, except in the one test that changes the code in the middle of a window on purpose. With a 2 MHz parameter the 64 ms window fits in the run. The longer codes are checked only for not rising early.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   localparam int SEL_W  = 3;
   localparam int MAX_US = 2_000_000;
   localparam int US_W   = $clog2(MAX_US + 1);

   typedef logic [US_W-1:0]  us_t;
   typedef logic [SEL_W-1:0] sel_t;

   // Stability window in microseconds for each selection code.
   function automatic us_t period_us(input sel_t sel);
      case (sel)
         3'd0:    period_us = us_t'(0);
         3'd1:    period_us = us_t'(500);
         3'd2:    period_us = us_t'(1_000);
         3'd3:    period_us = us_t'(64_000);
         3'd4:    period_us = us_t'(256_000);
         3'd5:    period_us = us_t'(512_000);
         3'd6:    period_us = us_t'(1_000_000);
         default: period_us = us_t'(MAX_US);
      endcase
   endfunction
endpackage

// File: rtl/lsq_us_tick.sv
module lsq_us_tick #(
   parameter int CLK_MHZ = 156
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("lsq_us_tick: CLK_MHZ must be at least 1");
   end

   if (CLK_MHZ == 1) begin : g_direct
      assign tick = run;
   end else begin : g_divide
      localparam int PW = $clog2(CLK_MHZ);
      localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);
      logic [PW-1:0] pre;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           pre <= '0;
         else if (!run)        pre <= '0;
         else if (pre == LAST) pre <= '0;
         else                  pre <= pre + 1'b1;
      end

      assign tick = run && (pre == LAST);

      // Ticks are never back to back when dividing (R2 timing base).
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/lsq_window_count.sv
module lsq_window_count #(
   parameter int CNT_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2) begin : g_bad_width
      $error("lsq_window_count: CNT_W too small");
   end

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count <= '0;
      else if (clear)                  count <= '0;
      else if (tick && count != TOP)   count <= count + 1'b1;
   end

   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

   assert_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clear) |-> (count >= $past(count)));
endmodule

// File: rtl/link_stability_qualifier.sv
module link_stability_qualifier #(
   parameter int CLK_MHZ     = 156,
   parameter int DEFAULT_SEL = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       link_raw,
   input  logic [2:0] period_sel,
   output logic       link_up
);
   import lsq_pkg::*;

   if (DEFAULT_SEL < 0 || DEFAULT_SEL > 7) begin : g_bad_default
      $error("link_stability_qualifier: DEFAULT_SEL out of range");
   end

   sel_t sel_hold;
   us_t  us_cnt;
   us_t  target;
   logic run;
   logic tick;
   logic lost;

   assign lost = !link_raw;
   assign run  = link_raw && !link_up;

   // Selection is captured only while the link is down (R6, R7).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_hold <= sel_t'(DEFAULT_SEL);
      else if (lost) sel_hold <= period_sel;
   end

   assign target = period_us(sel_hold);

   lsq_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   lsq_window_count #(.CNT_W(US_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (lost),
      .tick  (tick),
      .count (us_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           link_up <= 1'b0;
      else if (lost)                        link_up <= 1'b0;
      else if (!link_up && us_cnt >= target) link_up <= 1'b1;
   end

   assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !link_raw |=> !link_up);

   assert_rise_needs_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(link_raw));

   assert_instant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (link_raw && !link_up && sel_hold == '0) |=> link_up);

   assert_sel_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_raw && $past(link_raw)) |-> $stable(sel_hold));

   assert_no_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (link_raw && !link_up && us_cnt < target) |=> !link_up);
endmodule

// File: tb/link_stability_qualifier_test.sv
module link_stability_qualifier_test;
   localparam time CLK_PERIOD = 10ns;
   localparam int  MHZ        = 2;
   localparam int  WATCHDOG   = 190_000;

   typedef struct {
      int    cyc;
      bit    val;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_raw = 1'b1;
   logic [2:0] period_sel = 3'd0;
   logic       link_up;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   exp_t sb[$];

   link_stability_qualifier #(.CLK_MHZ(MHZ), .DEFAULT_SEL(2)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_raw   (link_raw),
      .period_sel (period_sel),
      .link_up    (link_up)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compares link_up against queued expectations at falling edges.
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (e.cyc != cyc) begin
            n_fail++;
            $display("FAIL %s: check for edge %0d missed (now %0d)", e.tag, e.cyc, cyc);
         end else if (link_up !== e.val) begin
            n_fail++;
            $display("FAIL %s: edge %0d link_up=%b expected %b", e.tag, cyc, link_up, e.val);
         end
      end
   end

   task automatic expect_at(input int c, input bit v, input string tag);
      sb.push_back('{cyc: c, val: v, tag: tag});
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Drop the link; qualified output must clear on the next edge (R4, R8).
   task automatic drop_link();
      link_raw = 1'b0;
      expect_at(cyc + 1, 1'b0, "R4");
      expect_at(cyc + 4, 1'b0, "R8");
      wait_n(5);
   endtask

   // Set a code while down, then raise and expect the rise at N*MHZ edges.
   task automatic qualify(input logic [2:0] sel, input int us, input string tag);
      period_sel = sel;
      wait_n(2);
      link_raw = 1'b1;
      if (us == 0) begin
         expect_at(cyc + 1, 1'b1, tag);
      end else begin
         expect_at(cyc + us * MHZ, 1'b0, tag);
         expect_at(cyc + us * MHZ + 1, 1'b1, tag);
      end
      wait_n(us * MHZ + 3);
   endtask

   initial begin
      int n;
      // R7: reset state, link held high through reset with code 0 applied.
      wait_n(2);
      expect_at(cyc + 1, 1'b0, "R7");
      wait_n(2);
      rst_n = 1'b1;
      n = cyc;
      expect_at(n + 1000 * MHZ, 1'b0, "R7");
      expect_at(n + 1000 * MHZ + 1, 1'b1, "R7");
      wait_n(1000 * MHZ + 3);
      drop_link();

      // R3: instantaneous code.
      qualify(3'd0, 0, "R3");
      drop_link();

      // R1/R2: 500 us and 1 ms windows.
      qualify(3'd1, 500, "R2");
      drop_link();
      qualify(3'd2, 1000, "R1");
      drop_link();

      // R5: a one-edge drop inside the window restarts it.
      period_sel = 3'd1;
      wait_n(2);
      link_raw = 1'b1;
      n = cyc;
      wait_n(900);
      link_raw = 1'b0;
      wait_n(1);
      link_raw = 1'b1;
      expect_at(n + 500 * MHZ + 1, 1'b0, "R5");
      expect_at(n + 901 + 500 * MHZ, 1'b0, "R5");
      expect_at(n + 902 + 500 * MHZ, 1'b1, "R5");
      wait_n(500 * MHZ + 10);
      drop_link();

      // R6: code change during the window and while up is ignored.
      period_sel = 3'd2;
      wait_n(2);
      link_raw = 1'b1;
      n = cyc;
      wait_n(10);
      period_sel = 3'd0;
      expect_at(n + 11, 1'b0, "R6");
      expect_at(n + 1000 * MHZ, 1'b0, "R6");
      expect_at(n + 1000 * MHZ + 1, 1'b1, "R6");
      wait_n(1000 * MHZ + 3);
      period_sel = 3'd1;
      expect_at(cyc + 50, 1'b1, "R6");
      wait_n(52);
      drop_link();

      // R1: 64 ms window.
      qualify(3'd3, 64_000, "R1");
      drop_link();

      // R1: 2 s code does not rise early.
      period_sel = 3'd7;
      wait_n(2);
      link_raw = 1'b1;
      expect_at(cyc + 5000, 1'b0, "R1");
      wait_n(5002);
      drop_link();

      wait (sb.size() == 0);
      wait_n(2);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      wait_n(WATCHDOG);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d edges, expected < %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule